// File: doc/BRIEF.md
# Floating-Point Exception Status Register

This block holds the floating-point status word and updates its exception fields each time an arithmetic operation retires. The producing datapath strobes `op_done` together with a 5-bit vector of the exceptions it raised. The exceptions are detected before rounding, and computing them is outside this block. The block compares that vector with the trap-enable field held in the register itself. If no enabled exception was raised, the raw vector becomes the current-exception field and is also folded into the sticky accrued field. If at least one enabled exception was raised, the block raises a one-cycle trap request. In that case it reduces the vector to a single exception, leaves the accrued field as it is, and marks the trap-type field as an IEEE exception.

Software reads the whole word on `status_q` and can overwrite it through a full-word write port. A write lands on the same clock edge at which it is presented, and it overrides a completion in that cycle. All updates are registered: the new word and the trap pulse appear in the cycle after the edge that sampled the strobes. The positions of all fields are parameters, and so is the choice between two structures for the priority picker.

Top module: `fpx_status_reg`

## Requirements
- R1: While `rst_n` is low and after its release, `status_q` is all zeros and `trap_req` is low.
- R2: A completion traps when `op_done` is high, `sw_wr_en` is low and `op_exc` ANDed with the enable field (bits 27:23) is nonzero. `trap_req` is then high for exactly the one cycle after that clock edge, and it is low in every other cycle.
- R3: On a trap, the current field (bits 4:0) holds exactly one bit. That bit is the highest-priority bit of `op_exc` that is also enabled. Raised bits that are not enabled are ignored. The bit encoding in every 5-bit field is invalid=4, overflow=3, underflow=2, divide-by-zero=1, inexact=0, and a higher bit index has higher priority.
- R4: On a completion without a trap, the current field is replaced by `op_exc` unchanged, and an all-zero vector clears it.
- R5: On a completion without a trap, the accrued field (bits 9:5) becomes its old value ORed with `op_exc`. On a trap it keeps its old value.
- R6: The trap-type field (bits 16:14) becomes 3'b001 on a trap and 3'b000 on a completion without a trap.
- R7: A completion leaves every bit outside the current, accrued and trap-type fields unchanged, and this includes the enable field.
- R8: When `sw_wr_en` is high, the next `status_q` equals `sw_wr_data` in all bits, `op_done` in the same cycle is ignored, and no trap is requested.
- R9: With `sw_wr_en` and `op_done` both low, `status_q` holds its value and `trap_req` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_wr_en | input | 1 | Software full-word write strobe |
| sw_wr_data | input | 32 | Word written when `sw_wr_en` is high |
| op_done | input | 1 | Operation completion strobe |
| op_exc | input | 5 | Exceptions raised by the completing operation |
| status_q | output | 32 | Current status word |
| trap_req | output | 1 | One-cycle trap request |

## Verification
The bench targets cases where several enabled exceptions arrive together. A picker with the wrong priority order would report overflow where invalid belongs, or underflow where divide-by-zero should lose. It also raises exceptions that are present but not enabled next to an enabled one. A design that failed to mask before picking would record the disabled invalid bit instead of the enabled inexact bit. The bench strobes a write and a completion in the same cycle: a design that lets the completion win would corrupt the written word or emit a spurious trap. A long random run covers the accrued field. A design that keeps accumulating during traps, or does not clear the trap type on clean completions, would drift from the model.

// File: rtl/fpx_pkg.sv
`timescale 1ns/1ps
package fpx_pkg;

   localparam int unsigned EXC_W = 5;

   typedef enum logic [2:0] {
      EXC_NX = 3'd0,
      EXC_DZ = 3'd1,
      EXC_UF = 3'd2,
      EXC_OF = 3'd3,
      EXC_NV = 3'd4
   } fpx_exc_idx_e;

   typedef logic [EXC_W-1:0] fpx_exc_t;

   typedef struct packed {
      logic     trap;
      fpx_exc_t cur;
      fpx_exc_t acc_set;
   } fpx_resolve_t;

   localparam int unsigned PRIO_RIPPLE = 0;
   localparam int unsigned PRIO_FLAT   = 1;

   function automatic bit fpx_overlap(int a_lsb, int a_w, int b_lsb, int b_w);
      return !((a_lsb + a_w <= b_lsb) || (b_lsb + b_w <= a_lsb));
   endfunction

endpackage

// File: rtl/fpx_prio_keep.sv
`timescale 1ns/1ps
// Keeps only the highest-index set bit of req.
module fpx_prio_keep #(
   parameter int unsigned W     = 5,
   parameter int unsigned STYLE = 0
) (
   input  logic [W-1:0] req,
   output logic [W-1:0] keep
);
   import fpx_pkg::*;

   if (W < 2) begin : g_bad_w
      $error("fpx_prio_keep: W must be at least 2");
   end
   if (STYLE != PRIO_RIPPLE && STYLE != PRIO_FLAT) begin : g_bad_style
      $error("fpx_prio_keep: unknown STYLE");
   end

   if (STYLE == PRIO_RIPPLE) begin : g_ripple
      // above[i] is set when any bit above i is requested
      logic [W-1:0] above;
      assign above[W-1] = 1'b0;
      assign keep[W-1]  = req[W-1];
      for (genvar i = 0; i < W - 1; i++) begin : g_bit
         assign above[i] = above[i+1] | req[i+1];
         assign keep[i]  = req[i] & ~above[i];
      end
   end else begin : g_flat
      for (genvar i = 0; i < W; i++) begin : g_bit
         if (i == W - 1) begin : g_top
            assign keep[i] = req[i];
         end else begin : g_low
            assign keep[i] = req[i] & ~(|req[W-1:i+1]);
         end
      end
   end

endmodule

// File: rtl/fpx_exc_resolve.sv
`timescale 1ns/1ps
// Decides trap versus accumulate for one completion.
module fpx_exc_resolve #(
   parameter int unsigned PRIO_STYLE = 0
) (
   input  fpx_pkg::fpx_exc_t     raised,
   input  fpx_pkg::fpx_exc_t     enable,
   output fpx_pkg::fpx_resolve_t res
);
   import fpx_pkg::*;

   if (int'(EXC_NV) != EXC_W - 1) begin : g_bad_order
      $error("fpx_exc_resolve: invalid must be the top priority bit");
   end

   fpx_exc_t enabled;
   fpx_exc_t single;
   logic     hit;

   assign enabled = raised & enable;
   assign hit     = |enabled;

   fpx_prio_keep #(
      .W     (EXC_W),
      .STYLE (PRIO_STYLE)
   ) u_pick (
      .req  (enabled),
      .keep (single)
   );

   always_comb begin
      res.trap    = hit;
      res.cur     = hit ? single : raised;
      res.acc_set = hit ? '0 : raised;
   end

endmodule

// File: rtl/fpx_field_merge.sv
`timescale 1ns/1ps
// Builds the next status word from the current one and the strobes.
module fpx_field_merge #(
   parameter int unsigned REG_W    = 32,
   parameter int unsigned CEXC_LSB = 0,
   parameter int unsigned AEXC_LSB = 5,
   parameter int unsigned TT_LSB   = 14,
   parameter int unsigned TT_W     = 3,
   parameter int unsigned TT_TRAP  = 1
) (
   input  logic [REG_W-1:0]       cur_q,
   input  logic                   sw_en,
   input  logic [REG_W-1:0]       sw_data,
   input  logic                   done,
   input  fpx_pkg::fpx_resolve_t  res,
   output logic [REG_W-1:0]       nxt,
   output logic                   trap_nxt
);
   import fpx_pkg::*;

   localparam logic [TT_W-1:0] TT_CODE = TT_W'(TT_TRAP);

   logic [REG_W-1:0] upd;

   for (genvar b = 0; b < REG_W; b++) begin : g_bit
      if (b >= CEXC_LSB && b < CEXC_LSB + EXC_W) begin : g_cexc
         assign upd[b] = res.cur[b-CEXC_LSB];
      end else if (b >= AEXC_LSB && b < AEXC_LSB + EXC_W) begin : g_aexc
         assign upd[b] = cur_q[b] | res.acc_set[b-AEXC_LSB];
      end else if (b >= TT_LSB && b < TT_LSB + TT_W) begin : g_tt
         assign upd[b] = res.trap & TT_CODE[b-TT_LSB];
      end else begin : g_keep
         assign upd[b] = cur_q[b];
      end
   end

   always_comb begin
      if (sw_en) begin
         nxt      = sw_data;
         trap_nxt = 1'b0;
      end else if (done) begin
         nxt      = upd;
         trap_nxt = res.trap;
      end else begin
         nxt      = cur_q;
         trap_nxt = 1'b0;
      end
   end

endmodule

// File: rtl/fpx_status_reg.sv
`timescale 1ns/1ps
module fpx_status_reg #(
   parameter int unsigned REG_W      = 32,
   parameter int unsigned TEM_LSB    = 23,
   parameter int unsigned AEXC_LSB   = 5,
   parameter int unsigned CEXC_LSB   = 0,
   parameter int unsigned TT_LSB     = 14,
   parameter int unsigned TT_W       = 3,
   parameter int unsigned TT_TRAP    = 1,
   parameter int unsigned PRIO_STYLE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_wr_en,
   input  logic [REG_W-1:0] sw_wr_data,
   input  logic             op_done,
   input  logic [4:0]       op_exc,
   output logic [REG_W-1:0] status_q,
   output logic             trap_req
);
   import fpx_pkg::*;

   // elaboration checks on the field layout
   if (TEM_LSB + EXC_W > REG_W || AEXC_LSB + EXC_W > REG_W ||
       CEXC_LSB + EXC_W > REG_W || TT_LSB + TT_W > REG_W) begin : g_bad_fit
      $error("fpx_status_reg: a field exceeds REG_W");
   end
   if (fpx_overlap(TEM_LSB, EXC_W, AEXC_LSB, EXC_W) ||
       fpx_overlap(TEM_LSB, EXC_W, CEXC_LSB, EXC_W) ||
       fpx_overlap(TEM_LSB, EXC_W, TT_LSB, TT_W) ||
       fpx_overlap(AEXC_LSB, EXC_W, CEXC_LSB, EXC_W) ||
       fpx_overlap(AEXC_LSB, EXC_W, TT_LSB, TT_W) ||
       fpx_overlap(CEXC_LSB, EXC_W, TT_LSB, TT_W)) begin : g_bad_overlap
      $error("fpx_status_reg: fields overlap");
   end
   if (TT_TRAP == 0 || TT_TRAP >= (1 << TT_W)) begin : g_bad_tt
      $error("fpx_status_reg: TT_TRAP must be nonzero and fit TT_W");
   end

   fpx_exc_t         tem;
   fpx_resolve_t     res;
   logic [REG_W-1:0] nxt;
   logic             trap_nxt;

   assign tem = status_q[TEM_LSB +: EXC_W];

   fpx_exc_resolve #(
      .PRIO_STYLE (PRIO_STYLE)
   ) u_resolve (
      .raised (op_exc),
      .enable (tem),
      .res    (res)
   );

   fpx_field_merge #(
      .REG_W    (REG_W),
      .CEXC_LSB (CEXC_LSB),
      .AEXC_LSB (AEXC_LSB),
      .TT_LSB   (TT_LSB),
      .TT_W     (TT_W),
      .TT_TRAP  (TT_TRAP)
   ) u_merge (
      .cur_q    (status_q),
      .sw_en    (sw_wr_en),
      .sw_data  (sw_wr_data),
      .done     (op_done),
      .res      (res),
      .nxt      (nxt),
      .trap_nxt (trap_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         trap_req <= 1'b0;
      end else begin
         status_q <= nxt;
         trap_req <= trap_nxt;
      end
   end

endmodule

// File: rtl/fpx_status_chk.sv
`timescale 1ns/1ps
module fpx_status_chk #(
   parameter int unsigned REG_W    = 32,
   parameter int unsigned TEM_LSB  = 23,
   parameter int unsigned AEXC_LSB = 5,
   parameter int unsigned CEXC_LSB = 0,
   parameter int unsigned TT_LSB   = 14,
   parameter int unsigned TT_W     = 3,
   parameter int unsigned TT_TRAP  = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sw_wr_en,
   input logic [REG_W-1:0] sw_wr_data,
   input logic             op_done,
   input logic [4:0]       op_exc,
   input logic [REG_W-1:0] status_q,
   input logic             trap_req
);

   logic [4:0] tem_w;
   logic [4:0] cexc_w;
   logic [4:0] aexc_w;
   assign tem_w  = status_q[TEM_LSB +: 5];
   assign cexc_w = status_q[CEXC_LSB +: 5];
   assign aexc_w = status_q[AEXC_LSB +: 5];

   p_trap_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> ($past(op_done) && !$past(sw_wr_en)));

   p_trap_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_done && !sw_wr_en && ((op_exc & tem_w) != 5'd0)) |=> trap_req);

   p_single_cexc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> ($countones(cexc_w) == 1));

   p_plain_cexc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_done && !sw_wr_en && ((op_exc & tem_w) == 5'd0)) |=> (cexc_w == $past(op_exc)));

   p_acc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> (aexc_w == $past(aexc_w)));

   p_trap_type_r6: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> (status_q[TT_LSB +: TT_W] == TT_W'(TT_TRAP)));

   p_tem_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_wr_en |=> $stable(tem_w));

   p_sw_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sw_wr_en |=> ((status_q == $past(sw_wr_data)) && !trap_req));

   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_wr_en && !op_done) |=> ($stable(status_q) && !trap_req));

endmodule

bind fpx_status_reg fpx_status_chk #(
   .REG_W    (REG_W),
   .TEM_LSB  (TEM_LSB),
   .AEXC_LSB (AEXC_LSB),
   .CEXC_LSB (CEXC_LSB),
   .TT_LSB   (TT_LSB),
   .TT_W     (TT_W),
   .TT_TRAP  (TT_TRAP)
) u_fpx_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sw_wr_en   (sw_wr_en),
   .sw_wr_data (sw_wr_data),
   .op_done    (op_done),
   .op_exc     (op_exc),
   .status_q   (status_q),
   .trap_req   (trap_req)
);

// File: tb/fpx_status_reg_tb.sv
`timescale 1ns/1ps
module fpx_status_reg_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sw_wr_en = 1'b0;
   logic [31:0] sw_wr_data = '0;
   logic        op_done = 1'b0;
   logic [4:0]  op_exc = '0;
   logic [31:0] status_q;
   logic        trap_req;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   logic [32:0] exp_q[$];
   string       tag_q[$];
   logic [31:0] model_reg = '0;

   always #10 clk = ~clk;   // 50 MHz

   fpx_status_reg u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .sw_wr_en   (sw_wr_en),
      .sw_wr_data (sw_wr_data),
      .op_done    (op_done),
      .op_exc     (op_exc),
      .status_q   (status_q),
      .trap_req   (trap_req)
   );

   // Reference model written from the requirements; returns {trap, next}
   function automatic logic [32:0] model(logic [31:0] cur, logic sw_en,
                                         logic [31:0] sw_d, logic done,
                                         logic [4:0] exc);
      logic [4:0]  en;
      logic [4:0]  pick;
      logic [31:0] n;
      n = cur;
      if (sw_en) return {1'b0, sw_d};
      if (!done) return {1'b0, cur};
      en = exc & cur[27:23];
      if (en != 5'd0) begin
         if (en[4])      pick = 5'b10000;
         else if (en[3]) pick = 5'b01000;
         else if (en[2]) pick = 5'b00100;
         else if (en[1]) pick = 5'b00010;
         else            pick = 5'b00001;
         n[4:0]   = pick;
         n[16:14] = 3'b001;
         return {1'b1, n};
      end
      n[4:0]   = exc;
      n[9:5]   = cur[9:5] | exc;
      n[16:14] = 3'b000;
      return {1'b0, n};
   endfunction

   task automatic step(input logic sw_en, input logic [31:0] sw_d,
                       input logic done, input logic [4:0] exc, input string tag);
      logic [32:0] e;
      @(negedge clk);
      sw_wr_en   = sw_en;
      sw_wr_data = sw_d;
      op_done    = done;
      op_exc     = exc;
      e = model(model_reg, sw_en, sw_d, done, exc);
      model_reg = e[31:0];
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   // Monitor: compares after each edge once an item is pending
   always @(posedge clk) begin
      logic [32:0] e;
      string       t;
      #2;
      if (exp_q.size() > 0) begin
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_checks++;
         if ({trap_req, status_q} !== e) begin
            n_fail++;
            $display("FAIL %s: got trap=%0b status=%08h, expected trap=%0b status=%08h",
                     t, trap_req, status_q, e[32], e[31:0]);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      n_checks++;
      if (status_q !== 32'h0 || trap_req !== 1'b0) begin
         n_fail++;
         $display("FAIL R1 in reset: got %08h/%0b, expected 00000000/0", status_q, trap_req);
      end
      rst_n = 1'b1;
      @(negedge clk);
      n_checks++;
      if (status_q !== 32'h0 || trap_req !== 1'b0) begin
         n_fail++;
         $display("FAIL R1 after release: got %08h/%0b, expected 00000000/0", status_q, trap_req);
      end

      // clean completions with all traps disabled
      step(1'b0, '0, 1'b1, 5'b00001, "R4 R5 inexact only");
      step(1'b0, '0, 1'b1, 5'b10010, "R4 R5 invalid+divzero");
      step(1'b0, '0, 1'b1, 5'b00000, "R4 zero vector clears current");
      step(1'b0, '0, 1'b0, 5'b11111, "R9 idle ignores op_exc");
      step(1'b0, '0, 1'b0, 5'b00000, "R9 idle hold");

      // all traps enabled, other bits populated
      step(1'b1, 32'h4F80_C0A5, 1'b0, 5'b0, "R8 full-word write");
      step(1'b0, '0, 1'b1, 5'b11111, "R2 R3 R6 R7 invalid wins");
      step(1'b0, '0, 1'b0, 5'b00000, "R2 trap pulse ends");
      step(1'b0, '0, 1'b1, 5'b01100, "R3 overflow beats underflow");
      step(1'b0, '0, 1'b1, 5'b00011, "R3 R5 divzero beats inexact, accrued held");

      // only inexact enabled: disabled invalid must be ignored
      step(1'b1, 32'h0080_0000, 1'b0, 5'b0, "R8 enable inexact only");
      step(1'b0, '0, 1'b1, 5'b10001, "R3 disabled bits masked");
      step(1'b0, '0, 1'b1, 5'b10000, "R4 R5 R6 no trap clears type");

      // write collides with a trapping completion
      step(1'b1, 32'h0F80_0000, 1'b1, 5'b11111, "R8 write beats completion");
      step(1'b1, 32'h0300_0000, 1'b0, 5'b0, "R8 enable underflow+divzero");
      step(1'b0, '0, 1'b1, 5'b00110, "R3 underflow beats divzero");
      step(1'b0, '0, 1'b1, 5'b11001, "R4 R5 R7 unenabled raise accrues");

      // random mix
      for (int k = 0; k < 200; k++) begin
         logic [31:0] r;
         r = $urandom;
         if (r[2:0] == 3'd0)
            step(1'b1, $urandom, r[3], r[8:4], "R8 random write");
         else
            step(1'b0, '0, r[3] | r[9], r[8:4], "R2 R3 R5 R6 random");
      end

      step(1'b0, '0, 1'b0, 5'b0, "R9 final idle");
      wait (exp_q.size() == 0);
      @(negedge clk);
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule